// File: doc/BRIEF.md
# Iterative Linear Regression Track Filter

The block takes one track candidate at a time as a short list of stubs. Each stub carries a radius `r`, an azimuthal coordinate `phi`, a longitudinal coordinate `z` and a detector layer number. The block fits two straight lines by least squares, `phi` against `r` and `z` against `r`. Their slopes and intercepts are the four track parameters: the r-phi slope, which tracks charge over transverse momentum, the azimuth at the origin, `z0`, and the r-z slope, which is the polar-angle term.

After each fit every surviving stub gets a residual in both projections. The cut applied to those residuals depends on how many distinct layers the track still covers. If any stub fails a cut, the stub with the largest combined residual is dropped and the track is fitted again. The candidate is rejected when the layer coverage falls below a minimum, or when the fit becomes degenerate. When a fit passes the cuts in both projections, one shared sequential divider turns the fit terms into fixed-point parameters. The result is presented on a valid/ready output.

Top module: `lrf_track_filter`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: While `in_ready` is 1, each cycle with `in_valid` high stores one stub. A candidate closes on the stub flagged `in_last`, or on the 16th stub even if `in_last` is low. `in_ready` stays 0 from that point until the result has been taken, so `in_ready` and `out_valid` are never both 1.
- R3: Each fit runs over the stubs still alive. With count N and sums Sr, Srr, Sy and Sry (y standing for phi or z), the fit forms D = N·Srr − Sr², A_y = Srr·Sy − Sr·Sry and B_y = N·Sry − Sr·Sy.
- R4: A stub's scaled residual is e_y = |D·y − A_y − B_y·r|. The stub fails if e_phi > Tphi·D or if e_z > Tz·D. Tphi and Tz take their loose values (8, 8) when the live stubs cover at least 6 distinct layers, and their tight values (3, 3) otherwise.
- R5: If any stub fails, the stub with the largest e_phi + e_z is removed, with the lowest slot winning a tie. The fit then repeats. Each pass removes at most one stub, and a removed stub never returns within the candidate.
- R6: If the live stubs cover fewer than 4 distinct layers, or if D ≤ 0, the result is a reject. In that case `out_accept` is 0 and all four parameters are 0.
- R7: When no stub fails, the result is an accept (`out_accept` = 1). The four parameters are (B_phi·2^8)/D, (A_phi·2^8)/D, (B_z·2^8)/D and (A_z·2^8)/D, each divided with truncation toward zero. They appear on `out_phi_slope`, `out_phi0`, `out_z_slope` and `out_z0` in that order.
- R8: `out_nstub` is the number of stubs in the deciding fit. While `out_valid` is 1 and `out_ready` is 0, all outputs hold steady. The cycle after a handshake, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stub present |
| in_ready | output | 1 | Block is collecting stubs |
| in_r | input | RW | Stub radius, unsigned |
| in_phi | input | YW | Stub azimuth, signed |
| in_z | input | YW | Stub longitudinal position, signed |
| in_layer | input | LAYW | Stub layer number |
| in_last | input | 1 | Final stub of the candidate |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result consumer ready |
| out_accept | output | 1 | 1 = track kept, 0 = rejected |
| out_nstub | output | CW | Stubs used by the deciding fit |
| out_phi_slope | output | WW | r-phi slope, FRAC fraction bits |
| out_phi0 | output | WW | r-phi intercept, FRAC fraction bits |
| out_z_slope | output | WW | r-z slope, FRAC fraction bits |
| out_z0 | output | WW | r-z intercept, FRAC fraction bits |

## Verification
The bench builds the block with its default sizes: 16 stub slots, 8-bit coordinates, 3-bit layers, 48-bit arithmetic and 8 fraction bits. The thresholds are 8 loose and 3 tight, the minimum coverage is 4 layers and loose cuts start at 6 layers. At these sizes every slot, the 16-stub cap and every layer count from 1 to 8 are reachable. A bench-side model of the full refit loop therefore predicts the decision, the surviving count and all four quotients for each candidate. The candidates include directed cases for outlier removal, too few layers, the degenerate equal-radius fit and the boundary between tight and loose cuts, followed by a sweep of over a hundred generated candidates with mixed noise and outliers.

// File: rtl/lrf_pkg.sv
package lrf_pkg;
  typedef enum logic [2:0] {
    ST_LOAD, ST_SUM, ST_SOLVE, ST_RES, ST_DECIDE, ST_DIV, ST_OUT
  } lrf_state_e;
endpackage

// File: rtl/lrf_stub_store.sv
module lrf_stub_store #(
  parameter int DEPTH = 16,
  parameter int RW = 8,
  parameter int YW = 8,
  parameter int LW = 3,
  localparam int IW = $clog2(DEPTH),
  localparam int EW = RW + 2 * YW + LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [RW-1:0] wr_r,
  input  logic [YW-1:0] wr_phi,
  input  logic [YW-1:0] wr_z,
  input  logic [LW-1:0] wr_lay,
  input  logic          clr_all,
  input  logic          kill_en,
  input  logic [IW-1:0] kill_idx,
  input  logic [IW-1:0] rd_idx,
  output logic [RW-1:0] rd_r,
  output logic [YW-1:0] rd_phi,
  output logic [YW-1:0] rd_z,
  output logic [LW-1:0] rd_lay,
  output logic [DEPTH-1:0] vmask
);
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_r, wr_phi, wr_z, wr_lay};
  end

  assign {rd_r, rd_phi, rd_z, rd_lay} = mem[rd_idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic live;
    always_ff @(posedge clk) begin
      if (rst || clr_all)                          live <= 1'b0;
      else if (wr_en && wr_idx == IW'(g))          live <= 1'b1;
      else if (kill_en && kill_idx == IW'(g))      live <= 1'b0;
    end
    assign vmask[g] = live;
  end
endmodule

// File: rtl/lrf_divider.sv
module lrf_divider #(
  parameter int WW = 48,
  localparam int CNTW = $clog2(WW + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic signed [WW-1:0] num,
  input  logic signed [WW-1:0] den,
  output logic                 busy,
  output logic                 done,
  output logic signed [WW-1:0] quo
);
  logic [WW-1:0] q_m, d_m, rem_q, rem_n, q_n;
  logic [WW:0]   trial, trial_sub;
  logic          bit_n, neg_q;
  logic [CNTW-1:0] cnt;

  always_comb begin
    trial     = {rem_q, q_m[WW-1]};
    trial_sub = trial - {1'b0, d_m};
    if (trial >= {1'b0, d_m}) begin
      rem_n = trial_sub[WW-1:0];
      bit_n = 1'b1;
    end else begin
      rem_n = trial[WW-1:0];
      bit_n = 1'b0;
    end
    q_n = {q_m[WW-2:0], bit_n};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; quo <= '0; cnt <= '0;
      q_m <= '0; d_m <= '0; rem_q <= '0; neg_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        cnt   <= CNTW'(WW);
        q_m   <= num[WW-1] ? -num : num;
        d_m   <= den[WW-1] ? -den : den;
        rem_q <= '0;
        neg_q <= num[WW-1] ^ den[WW-1];
      end else if (busy) begin
        q_m   <= q_n;
        rem_q <= rem_n;
        cnt   <= cnt - CNTW'(1);
        if (cnt == CNTW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          quo  <= neg_q ? -q_n : q_n;
        end
      end
    end
  end

  AST_DIV_START_IDLE: assert property (@(posedge clk) disable iff (rst) start |-> !busy); // R7
  AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R7
endmodule

// File: rtl/lrf_track_filter.sv
module lrf_track_filter
  import lrf_pkg::*;
#(
  parameter int MAX_STUBS    = 16,
  parameter int RW           = 8,
  parameter int YW           = 8,
  parameter int LAYW         = 3,
  parameter int WW           = 48,
  parameter int FRAC         = 8,
  parameter int MIN_LAYERS   = 4,
  parameter int LOOSE_LAYERS = 6,
  parameter int TPHI_LOOSE   = 8,
  parameter int TPHI_TIGHT   = 3,
  parameter int TZ_LOOSE     = 8,
  parameter int TZ_TIGHT     = 3,
  localparam int IW   = $clog2(MAX_STUBS),
  localparam int CW   = $clog2(MAX_STUBS + 1),
  localparam int NLAY = 2 ** LAYW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [RW-1:0]        in_r,
  input  logic [YW-1:0]        in_phi,
  input  logic [YW-1:0]        in_z,
  input  logic [LAYW-1:0]      in_layer,
  input  logic                 in_last,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_accept,
  output logic [CW-1:0]        out_nstub,
  output logic signed [WW-1:0] out_phi_slope,
  output logic signed [WW-1:0] out_phi0,
  output logic signed [WW-1:0] out_z_slope,
  output logic signed [WW-1:0] out_z0
);
  localparam logic signed [WW-1:0] TPL = WW'(TPHI_LOOSE);
  localparam logic signed [WW-1:0] TPT = WW'(TPHI_TIGHT);
  localparam logic signed [WW-1:0] TZL = WW'(TZ_LOOSE);
  localparam logic signed [WW-1:0] TZT = WW'(TZ_TIGHT);

  lrf_state_e state;
  logic [IW-1:0] idx, worst_idx;
  logic [CW-1:0] load_cnt;
  logic signed [WW-1:0] s_n, s_r, s_rr, s_p, s_rp, s_z, s_rz;
  logic signed [WW-1:0] d_q, ap_q, bp_q, az_q, bz_q, tpd_q, tzd_q, worst_m;
  logic [NLAY-1:0] lmask;
  logic fail_q, have_w, div_launched;
  logic [1:0] div_k;

  logic [RW-1:0] rd_r;
  logic [YW-1:0] rd_phi, rd_z;
  logic [LAYW-1:0] rd_lay;
  logic [MAX_STUBS-1:0] vmask;
  logic wr_en, clr_all, kill_en;

  assign in_ready = (state == ST_LOAD);
  assign wr_en    = in_valid && in_ready;
  assign clr_all  = (state == ST_OUT) && out_ready;
  assign kill_en  = (state == ST_DECIDE) && fail_q;

  lrf_stub_store #(.DEPTH(MAX_STUBS), .RW(RW), .YW(YW), .LW(LAYW)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(load_cnt[IW-1:0]),
    .wr_r(in_r), .wr_phi(in_phi), .wr_z(in_z), .wr_lay(in_layer),
    .clr_all(clr_all), .kill_en(kill_en), .kill_idx(worst_idx),
    .rd_idx(idx), .rd_r(rd_r), .rd_phi(rd_phi), .rd_z(rd_z), .rd_lay(rd_lay),
    .vmask(vmask)
  );

  // Fit terms, residuals and divider operand selection
  logic signed [WW-1:0] r_x, p_x, z_x, d_c, ap_c, bp_c, az_c, bz_c;
  logic signed [WW-1:0] ep_raw, ez_raw, ep, ez, m_c, div_sel, div_num, div_quo;
  logic loose, div_start, div_busy, div_done;
  int   nlay_c;

  always_comb begin
    r_x    = {{(WW-RW){1'b0}}, rd_r};
    p_x    = {{(WW-YW){rd_phi[YW-1]}}, rd_phi};
    z_x    = {{(WW-YW){rd_z[YW-1]}}, rd_z};
    d_c    = s_n * s_rr - s_r * s_r;
    ap_c   = s_rr * s_p - s_r * s_rp;
    bp_c   = s_n * s_rp - s_r * s_p;
    az_c   = s_rr * s_z - s_r * s_rz;
    bz_c   = s_n * s_rz - s_r * s_z;
    nlay_c = $countones(lmask);
    loose  = nlay_c >= LOOSE_LAYERS;
    ep_raw = d_q * p_x - ap_q - bp_q * r_x;
    ez_raw = d_q * z_x - az_q - bz_q * r_x;
    ep     = ep_raw[WW-1] ? -ep_raw : ep_raw;
    ez     = ez_raw[WW-1] ? -ez_raw : ez_raw;
    m_c    = ep + ez;
    case (div_k)
      2'd0:    div_sel = bp_q;
      2'd1:    div_sel = ap_q;
      2'd2:    div_sel = bz_q;
      default: div_sel = az_q;
    endcase
    div_num   = div_sel <<< FRAC;
    div_start = (state == ST_DIV) && !div_launched;
  end

  lrf_divider #(.WW(WW)) u_div (
    .clk(clk), .rst(rst), .start(div_start), .num(div_num), .den(d_q),
    .busy(div_busy), .done(div_done), .quo(div_quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_LOAD; idx <= '0; load_cnt <= '0; lmask <= '0;
      s_n <= '0; s_r <= '0; s_rr <= '0; s_p <= '0; s_rp <= '0; s_z <= '0; s_rz <= '0;
      d_q <= '0; ap_q <= '0; bp_q <= '0; az_q <= '0; bz_q <= '0; tpd_q <= '0; tzd_q <= '0;
      fail_q <= 1'b0; have_w <= 1'b0; worst_m <= '0; worst_idx <= '0;
      div_k <= '0; div_launched <= 1'b0;
      out_valid <= 1'b0; out_accept <= 1'b0; out_nstub <= '0;
      out_phi_slope <= '0; out_phi0 <= '0; out_z_slope <= '0; out_z0 <= '0;
    end else begin
      case (state)
        ST_LOAD: if (wr_en) begin
          load_cnt <= load_cnt + CW'(1);
          if (in_last || load_cnt == CW'(MAX_STUBS - 1)) begin
            state <= ST_SUM;
            idx   <= '0;
          end
        end
        ST_SUM: begin
          if (vmask[idx]) begin
            s_n  <= s_n + WW'(1);
            s_r  <= s_r + r_x;
            s_rr <= s_rr + r_x * r_x;
            s_p  <= s_p + p_x;
            s_rp <= s_rp + r_x * p_x;
            s_z  <= s_z + z_x;
            s_rz <= s_rz + r_x * z_x;
            lmask[rd_lay] <= 1'b1;
          end
          if (idx == IW'(MAX_STUBS - 1)) state <= ST_SOLVE;
          else idx <= idx + IW'(1);
        end
        ST_SOLVE: begin
          d_q <= d_c; ap_q <= ap_c; bp_q <= bp_c; az_q <= az_c; bz_q <= bz_c;
          tpd_q <= (loose ? TPL : TPT) * d_c;
          tzd_q <= (loose ? TZL : TZT) * d_c;
          out_nstub <= s_n[CW-1:0];
          s_n <= '0; s_r <= '0; s_rr <= '0; s_p <= '0; s_rp <= '0; s_z <= '0; s_rz <= '0;
          lmask <= '0; idx <= '0; fail_q <= 1'b0; have_w <= 1'b0;
          if (nlay_c < MIN_LAYERS || d_c[WW-1] || d_c == '0) begin
            out_accept <= 1'b0; out_valid <= 1'b1;
            out_phi_slope <= '0; out_phi0 <= '0; out_z_slope <= '0; out_z0 <= '0;
            state <= ST_OUT;
          end else begin
            state <= ST_RES;
          end
        end
        ST_RES: begin
          if (vmask[idx]) begin
            if (ep > tpd_q || ez > tzd_q) fail_q <= 1'b1;
            if (!have_w || m_c > worst_m) begin
              worst_m <= m_c; worst_idx <= idx; have_w <= 1'b1;
            end
          end
          if (idx == IW'(MAX_STUBS - 1)) state <= ST_DECIDE;
          else idx <= idx + IW'(1);
        end
        ST_DECIDE: begin
          idx <= '0;
          if (fail_q) state <= ST_SUM;
          else begin
            state <= ST_DIV; div_k <= '0; div_launched <= 1'b0;
          end
        end
        ST_DIV: begin
          if (div_start) div_launched <= 1'b1;
          if (div_done) begin
            case (div_k)
              2'd0:    out_phi_slope <= div_quo;
              2'd1:    out_phi0      <= div_quo;
              2'd2:    out_z_slope   <= div_quo;
              default: out_z0        <= div_quo;
            endcase
            div_launched <= 1'b0;
            if (div_k == 2'd3) begin
              out_accept <= 1'b1; out_valid <= 1'b1; state <= ST_OUT;
            end else div_k <= div_k + 2'd1;
          end
        end
        ST_OUT: if (out_ready) begin
          out_valid <= 1'b0; load_cnt <= '0; state <= ST_LOAD;
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  AST_IN_OUT_EXCL: assert property (@(posedge clk) disable iff (rst) !(in_ready && out_valid)); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_accept) && $stable(out_nstub) &&
    $stable(out_phi_slope) && $stable(out_phi0) && $stable(out_z_slope) && $stable(out_z0)); // R8
  AST_NO_REVIVE: assert property (@(posedge clk) disable iff (rst)
    state != ST_LOAD |=> (vmask & ~$past(vmask)) == '0); // R5
  AST_ONE_DROP: assert property (@(posedge clk) disable iff (rst)
    state != ST_LOAD && state != ST_OUT |=> $countones($past(vmask)) - $countones(vmask) <= 1); // R5
  AST_ACCEPT_COVER: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_accept |-> out_nstub >= CW'(MIN_LAYERS)); // R6
  AST_DIV_IDLE_OUT: assert property (@(posedge clk) disable iff (rst)
    state != ST_DIV |-> !div_busy); // R7
endmodule

// File: tb/tb_lrf_track_filter.sv
module tb_lrf_track_filter;
  localparam int CLK_PERIOD = 10;
  localparam int MAXS = 16, RW = 8, YW = 8, LAYW = 3, WW = 48, FRAC = 8;
  localparam int MINL = 4, LOOSEL = 6, TPL = 8, TPT = 3, TZL = 8, TZT = 3;
  localparam int CW = $clog2(MAXS + 1);
  localparam int WDOG = 190000;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [RW-1:0] in_r = '0;
  logic [YW-1:0] in_phi = '0, in_z = '0;
  logic [LAYW-1:0] in_layer = '0;
  logic in_ready, out_valid, out_accept;
  logic [CW-1:0] out_nstub;
  logic signed [WW-1:0] out_phi_slope, out_phi0, out_z_slope, out_z0;

  lrf_track_filter #(
    .MAX_STUBS(MAXS), .RW(RW), .YW(YW), .LAYW(LAYW), .WW(WW), .FRAC(FRAC),
    .MIN_LAYERS(MINL), .LOOSE_LAYERS(LOOSEL), .TPHI_LOOSE(TPL), .TPHI_TIGHT(TPT),
    .TZ_LOOSE(TZL), .TZ_TIGHT(TZT)
  ) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_r(in_r),
    .in_phi(in_phi), .in_z(in_z), .in_layer(in_layer), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_accept(out_accept),
    .out_nstub(out_nstub), .out_phi_slope(out_phi_slope), .out_phi0(out_phi0),
    .out_z_slope(out_z_slope), .out_z0(out_z0)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0;
  int sr[MAXS], sp[MAXS], sz[MAXS], sl[MAXS];
  int ns = 0;
  int unsigned seed = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  function automatic int clamp(input int v);
    return (v > 127) ? 127 : ((v < -127) ? -127 : v);
  endfunction

  function automatic longint labs(input longint v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic add_stub(input int ly, input int r, input int p, input int z);
    sl[ns] = ly; sr[ns] = r; sp[ns] = clamp(p); sz[ns] = clamp(z); ns++;
  endtask

  // Reference: iterative fit, cut, remove worst (R3..R7)
  task automatic ref_run(output bit acc, output int nst, output longint q[4]);
    bit [MAXS-1:0] alive;
    alive = '0;
    for (int i = 0; i < ns; i++) alive[i] = 1'b1;
    while (1) begin
      longint n, s_r, s_rr, s_p, s_rp, s_z, s_rz, d, ap, bp, az, bz, tp, tz, wm;
      int mask, nl, wi;
      bit fail, have;
      n = 0; s_r = 0; s_rr = 0; s_p = 0; s_rp = 0; s_z = 0; s_rz = 0; mask = 0;
      for (int i = 0; i < MAXS; i++) if (alive[i]) begin
        n++; s_r += sr[i]; s_rr += longint'(sr[i]) * sr[i];
        s_p += sp[i]; s_rp += longint'(sr[i]) * sp[i];
        s_z += sz[i]; s_rz += longint'(sr[i]) * sz[i];
        mask |= (1 << sl[i]);
      end
      nl = $countones(mask);
      d = n * s_rr - s_r * s_r;
      nst = int'(n);
      if (nl < MINL || d <= 0) begin
        acc = 0; for (int k = 0; k < 4; k++) q[k] = 0;
        return;
      end
      ap = s_rr * s_p - s_r * s_rp; bp = n * s_rp - s_r * s_p;
      az = s_rr * s_z - s_r * s_rz; bz = n * s_rz - s_r * s_z;
      tp = ((nl >= LOOSEL) ? TPL : TPT) * d;
      tz = ((nl >= LOOSEL) ? TZL : TZT) * d;
      fail = 0; have = 0; wm = 0; wi = 0;
      for (int i = 0; i < MAXS; i++) if (alive[i]) begin
        longint ep, ez;
        ep = labs(d * sp[i] - ap - bp * sr[i]);
        ez = labs(d * sz[i] - az - bz * sr[i]);
        if (ep > tp || ez > tz) fail = 1;
        if (!have || ep + ez > wm) begin wm = ep + ez; wi = i; have = 1; end
      end
      if (!fail) begin
        acc = 1;
        q[0] = (bp * (64'sd1 <<< FRAC)) / d; q[1] = (ap * (64'sd1 <<< FRAC)) / d;
        q[2] = (bz * (64'sd1 <<< FRAC)) / d; q[3] = (az * (64'sd1 <<< FRAC)) / d;
        return;
      end
      alive[wi] = 1'b0;
    end
  endtask

  task automatic run_cand(input string tag, input bit use_last, input int hold,
                          input int exp_acc, input int exp_nst);
    bit acc; int nst; longint q[4];
    logic signed [WW-1:0] h0, h1, h2, h3;
    ref_run(acc, nst, q);
    for (int i = 0; i < ns; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_r = RW'(sr[i]); in_phi = YW'(sp[i]); in_z = YW'(sz[i]);
      in_layer = LAYW'(sl[i]); in_last = use_last && (i == ns - 1);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    while (!out_valid) @(negedge clk);
    check(out_accept == acc, "R4/R6", {tag, " accept"}, out_accept, acc);
    check(out_nstub == CW'(nst), "R5", {tag, " nstub"}, out_nstub, nst);
    check(longint'(out_phi_slope) == q[0], "R3/R7", {tag, " phi slope"}, out_phi_slope, q[0]);
    check(longint'(out_phi0) == q[1], "R3/R7", {tag, " phi0"}, out_phi0, q[1]);
    check(longint'(out_z_slope) == q[2], "R3/R7", {tag, " z slope"}, out_z_slope, q[2]);
    check(longint'(out_z0) == q[3], "R3/R7", {tag, " z0"}, out_z0, q[3]);
    if (exp_acc >= 0) check(out_accept == exp_acc[0], "R5/R6", {tag, " directed accept"}, out_accept, exp_acc);
    if (exp_nst >= 0) check(out_nstub == CW'(exp_nst), "R5", {tag, " directed nstub"}, out_nstub, exp_nst);
    h0 = out_phi_slope; h1 = out_phi0; h2 = out_z_slope; h3 = out_z0;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(out_valid && !in_ready, "R8", {tag, " hold valid"}, out_valid, 1);
      check(out_phi_slope == h0 && out_phi0 == h1 && out_z_slope == h2 && out_z0 == h3,
            "R8", {tag, " hold data"}, out_z0, h3);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R8", {tag, " after handshake"}, {out_valid, in_ready}, 2'b01);
    ns = 0;
  endtask

  task automatic line_track(input int nlay, input int first_ly, input int sl_p, input int off_p,
                            input int sl_z, input int off_z);
    for (int l = 0; l < nlay; l++) begin
      int r;
      r = 20 + 30 * l;
      add_stub(first_ly + l, r, off_p + (sl_p * r) / 64, off_z + (sl_z * r) / 64);
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid, "R1", "reset out_valid", out_valid, 0);
    check(in_ready, "R1", "reset in_ready", in_ready, 1);

    // clean six-layer track, loose cuts
    line_track(6, 0, 16, 5, -20, 3);
    run_cand("clean", 1'b1, 4, 1, 6);

    // same track plus an outlier on a duplicate layer: one removal (R5)
    line_track(6, 0, 16, 5, -20, 3);
    add_stub(3, 110, 5 + 110 / 4 + 50, 3 + (-20 * 110) / 64);
    run_cand("outlier", 1'b1, 1, 1, 6);

    // three distinct layers only: reject (R6)
    for (int i = 0; i < 6; i++) add_stub(i % 3, 30 + 25 * i, 10, -5);
    run_cand("few layers", 1'b1, 0, 0, 6);

    // equal radii give D = 0: reject (R6)
    for (int i = 0; i < 4; i++) add_stub(i, 100, 7 * i, -3 * i);
    run_cand("flat r", 1'b1, 0, 0, 4);

    // sixteen stubs without a last flag close the candidate (R2)
    for (int i = 0; i < 16; i++) add_stub(i % 8, 16 + 14 * i, -4 + (10 * (16 + 14 * i)) / 64, 2);
    run_cand("cap16", 1'b0, 2, -1, 16);

    // tight cuts at five layers versus loose cuts at six (R4)
    line_track(5, 0, 12, -3, 8, 1);
    sp[2] = sp[2] + 8;
    run_cand("tight", 1'b1, 0, -1, -1);
    line_track(6, 0, 12, -3, 8, 1);
    sp[2] = sp[2] + 5;
    run_cand("loose", 1'b1, 0, -1, -1);

    // generated sweep
    for (int c = 0; c < 110; c++) begin
      int n, slp, offp, slz, offz;
      n = 4 + int'(rnd() % 13);
      slp = int'(rnd() % 65) - 32; offp = int'(rnd() % 17) - 8;
      slz = int'(rnd() % 65) - 32; offz = int'(rnd() % 17) - 8;
      for (int i = 0; i < n; i++) begin
        int ly, r, np, nz;
        ly = i % 8;
        r = 16 + ly * 28 + int'(rnd() % 4);
        np = int'(rnd() % 3) - 1; nz = int'(rnd() % 3) - 1;
        if (rnd() % 5 == 0) np += int'(rnd() % 61) - 30;
        if (rnd() % 6 == 0) nz += int'(rnd() % 61) - 30;
        add_stub(ly, r, offp + (slp * r) / 64 + np, offz + (slz * r) / 64 + nz);
      end
      run_cand("sweep", 1'b1, c % 3, -1, -1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule